// File: doc/BRIEF.md
# External Memory Window Controller

This block sits between a 16-bit signal processor core and its external memories: a large DRAM region, a program ROM and a small instruction RAM. The core sees five access registers. Any of them can be turned into a window onto memory by programming an address/mode pair. The pair then follows every read or write made through that register and moves the address by a step after each access.

Software programs a shared configuration register with two 16-bit writes, the address word first and the mode word second. The next read or write through an access register copies that pair into the register's read slot or write slot, depending on the direction of that access. The same access already goes to memory with the new pair. Each register therefore has an independent read stream and write stream. Register 4 always acts as a window. The other registers act as windows only while one of the two steering status bits is set, and otherwise behave as plain 16-bit storage. The memory arrays are outside the block. A request is issued in the same cycle as the access strobe, and read data is expected back in that same cycle.

Top module: `pmac_ctrl`

## Requirements
- R1: After reset, no memory request or error is raised, read data is zero, every slot and the configuration pair are zero, and the configuration register expects its address word.
- R2: Configuration accesses alternate between an address phase and a mode phase. A write in the address phase stores the address word and a write in the mode phase stores the mode word. The first access-register strobe after the mode phase arms that register with the stored pair and is itself served using that pair.
- R3: Every access register keeps a read slot and a write slot. An arming read loads only the read slot, an arming write loads only the write slot, and reads and writes then step their own slots.
- R4: The byte address of a DRAM or ROM request is {mode[6:0], address[15:0], 1'b0}, a 24-bit value. The target code is 0 for DRAM, 1 for ROM and 2 for instruction RAM.
- R5: These read modes target DRAM and step the 16-bit address, wrapping, after each access: 0x0018 no step, 0x0818 +1, 0x3018 +32, 0xA818 -16, 0xB818 -128.
- R6: Read mode 0x0809 targets ROM and steps the address by +1.
- R7: Write modes 0x0018 (no step) and 0x0818 (+1) target DRAM. Write mode 0x4018 adds 31 when the current address is odd and adds 1 when it is even.
- R8: Write modes 0x081C (+1) and 0x101C (+2) target instruction RAM with byte address {13'b0, address[9:0], 1'b0}. The step still applies to the full 16-bit address.
- R9: A configuration read returns the address word in the address phase and the mode word in the mode phase, and advances the phase exactly as a write does. The stored pair is replaced by the pair of the most recently armed slot and then by that slot's stepped pair after every memory access.
- R10: An access register is routed to memory when it is register 4 or when the steering input is non-zero. Otherwise a write stores into its plain register, a read returns that value, and no request is made.
- R11: A routed access whose slot holds a mode not listed for its direction raises the error output for that cycle, makes no request, returns zero and leaves the slot address unchanged.
- R12: Slots belong to one register. Arming or stepping one register leaves every other register's slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_sel | input | 3 | Access register index, 0 to 4 |
| acc_rd | input | 1 | Read strobe on the selected access register |
| acc_wr | input | 1 | Write strobe on the selected access register |
| cfg_rd | input | 1 | Read strobe on the configuration register |
| cfg_wr | input | 1 | Write strobe on the configuration register |
| wdata | input | 16 | Write data for either register kind |
| gp_sel | input | 2 | Steering status bits; non-zero routes every register |
| mem_rdata | input | 16 | Read data returned by memory in the request cycle |
| mem_req | output | 1 | Memory request, valid in the strobe cycle |
| mem_we | output | 1 | Request is a write |
| mem_tgt | output | 2 | Target: 0 DRAM, 1 ROM, 2 instruction RAM |
| mem_addr | output | 24 | Byte address of the request |
| mem_wdata | output | 16 | Write data toward memory |
| rdata | output | 16 | Read data toward the core |
| mode_err | output | 1 | Unknown mode hit by a routed access |

## Verification
The properties take for granted that at most one of the four strobes is high in any cycle, that the register index is in range whenever a strobe is high, and that memory answers a read in the request cycle. The scoreboard driver raises exactly one strobe for exactly one cycle per call and always uses indices 0 to 4. The bench memory model answers combinationally from the presented address, so the stimulus never steps outside these assumptions. The programmed sequences never leave the configuration register in its mode phase before a new address word, so every two-write program lands in the intended fields.

// File: rtl/pmac_pkg.sv
// Package: shared widths, target and phase encodings, slot type and the
// mode codes of the external memory window controller.
package pmac_pkg;
    localparam int WORD_W    = 16;
    localparam int MODE_LO_W = 7;
    localparam int IRAM_AW   = 10;
    localparam int BADDR_W   = MODE_LO_W + WORD_W + 1;

    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_IRAM = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        CFG_WANT_ADDR = 2'd0,
        CFG_WANT_MODE = 2'd1,
        CFG_PENDING   = 2'd2
    } cfg_ph_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] mode;
    } slot_t;

    // mode codes shared by both directions
    localparam logic [WORD_W-1:0] MD_HOLD     = 16'h0018;
    localparam logic [WORD_W-1:0] MD_INC1     = 16'h0818;
    // read-only codes
    localparam logic [WORD_W-1:0] MD_INC32    = 16'h3018;
    localparam logic [WORD_W-1:0] MD_DEC16    = 16'hA818;
    localparam logic [WORD_W-1:0] MD_DEC128   = 16'hB818;
    localparam logic [WORD_W-1:0] MD_ROM_INC1 = 16'h0809;
    // write-only codes
    localparam logic [WORD_W-1:0] MD_CELL     = 16'h4018;
    localparam logic [WORD_W-1:0] MD_IR_INC1  = 16'h081C;
    localparam logic [WORD_W-1:0] MD_IR_INC2  = 16'h101C;
endpackage

// File: rtl/pmac_mode_dec.sv
// Mode decoder: turns a slot's address/mode pair and the access direction
// into a valid flag, a target, the request byte address and the stepped
// address. Purely combinational; assumes one access per cycle.
module pmac_mode_dec
    import pmac_pkg::*;
(
    input  logic [WORD_W-1:0]  mode,
    input  logic [WORD_W-1:0]  addr,
    input  logic               is_wr,
    output logic               ok,
    output tgt_e               tgt,
    output logic [WORD_W-1:0]  next_addr,
    output logic [BADDR_W-1:0] byte_addr
);
    logic [WORD_W-1:0] step;

    // Decode the mode code per direction into target and step.
    always_comb begin
        ok   = 1'b1;
        tgt  = TGT_DRAM;
        step = '0;
        if (is_wr) begin
            case (mode)
                MD_HOLD:    step = '0;
                MD_INC1:    step = 16'd1;
                MD_CELL:    step = addr[0] ? 16'd31 : 16'd1;
                MD_IR_INC1: begin tgt = TGT_IRAM; step = 16'd1; end
                MD_IR_INC2: begin tgt = TGT_IRAM; step = 16'd2; end
                default:    ok = 1'b0;
            endcase
        end else begin
            case (mode)
                MD_HOLD:     step = '0;
                MD_INC1:     step = 16'd1;
                MD_INC32:    step = 16'd32;
                MD_DEC16:    step = 16'hFFF0;
                MD_DEC128:   step = 16'hFF80;
                MD_ROM_INC1: begin tgt = TGT_ROM; step = 16'd1; end
                default:     ok = 1'b0;
            endcase
        end
    end

    // Form the stepped address and the byte address for the target.
    always_comb begin
        next_addr = addr + step;
        if (tgt == TGT_IRAM)
            byte_addr = {{(BADDR_W-IRAM_AW-1){1'b0}}, addr[IRAM_AW-1:0], 1'b0};
        else
            byte_addr = {mode[MODE_LO_W-1:0], addr, 1'b0};
    end
endmodule

// File: rtl/pmac_cfg_seq.sv
// Configuration sequencer: holds the shared address/mode pair and the
// two-step programming phase. Reads and writes advance the phase alike;
// an access strobe while pending arms and returns to the address phase.
// Assumes configuration and access strobes never coincide.
module pmac_cfg_seq
    import pmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic              acc_any,
    input  logic [WORD_W-1:0] wdata,
    input  logic              update_en,
    input  slot_t             update_slot,
    output cfg_ph_e           phase,
    output slot_t             pair,
    output logic              arm,
    output logic [WORD_W-1:0] cfg_rdata
);
    // Phase and pair update on configuration and access strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= CFG_WANT_ADDR;
            pair  <= '0;
        end else if (cfg_wr || cfg_rd) begin
            if (phase == CFG_WANT_MODE) begin
                if (cfg_wr) pair.mode <= wdata;
                phase <= CFG_PENDING;
            end else begin
                if (cfg_wr) pair.addr <= wdata;
                phase <= CFG_WANT_MODE;
            end
        end else if (acc_any) begin
            if (phase == CFG_PENDING) phase <= CFG_WANT_ADDR;
            if (update_en) pair <= update_slot;
        end
    end

    // Arming condition and phase-dependent readback.
    always_comb begin
        arm       = acc_any && (phase == CFG_PENDING);
        cfg_rdata = (phase == CFG_WANT_MODE) ? pair.mode : pair.addr;
    end
endmodule

// File: rtl/pmac_slot_bank.sv
// Slot bank: one read slot and one write slot per access register.
// A load writes only the slot picked by register index and direction.
// Assumes sel is in range whenever load_en is high.
module pmac_slot_bank
    import pmac_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             is_wr,
    input  logic             load_en,
    input  slot_t            load_val,
    output slot_t            cur
);
    slot_t [NUM_REGS-1:0] rd_q;
    slot_t [NUM_REGS-1:0] wr_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        slot_t rd_r;
        slot_t wr_r;
        // Load this register's slot for the access direction.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_r <= '0;
                wr_r <= '0;
            end else if (load_en && (sel == SEL_W'(g))) begin
                if (is_wr) wr_r <= load_val;
                else       rd_r <= load_val;
            end
        end
        assign rd_q[g] = rd_r;
        assign wr_q[g] = wr_r;
    end

    // Select the slot addressed by the current access.
    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (sel == SEL_W'(i)) cur = is_wr ? wr_q[i] : rd_q[i];
    end
endmodule

// File: rtl/pmac_ctrl.sv
// External memory window controller top. Routes access-register strobes
// either to memory through an armed address/mode slot or to plain
// registers, and issues the memory request in the strobe cycle.
// Assumes one strobe per cycle and same-cycle memory read data.
module pmac_ctrl
    import pmac_pkg::*;
#(
    parameter int NUM_REGS  = 5,
    parameter int ROUTE_REG = 4,
    parameter int SEL_W     = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   acc_sel,
    input  logic               acc_rd,
    input  logic               acc_wr,
    input  logic               cfg_rd,
    input  logic               cfg_wr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [1:0]         gp_sel,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [1:0]         mem_tgt,
    output logic [BADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic [WORD_W-1:0]  rdata,
    output logic               mode_err
);
    logic              sel_ok;
    logic              acc_any;
    logic              routed;
    logic              arm;
    logic              do_mem;
    cfg_ph_e           cfg_phase;
    slot_t             cfg_pair;
    slot_t             stored;
    slot_t             cur;
    slot_t             stepped;
    logic [WORD_W-1:0] cfg_rdata;
    logic              dec_ok;
    tgt_e              dec_tgt;
    logic [WORD_W-1:0] dec_next;
    logic [BADDR_W-1:0] dec_baddr;
    logic [WORD_W-1:0] plain_sel;
    logic [NUM_REGS-1:0][WORD_W-1:0] plain_q;

    // Strobe qualification and routing decision.
    always_comb begin
        sel_ok  = int'(acc_sel) < NUM_REGS;
        acc_any = (acc_rd || acc_wr) && sel_ok;
        routed  = (acc_sel == SEL_W'(ROUTE_REG)) || (gp_sel != 2'b00);
    end

    pmac_cfg_seq u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_rd      (cfg_rd),
        .acc_any     (acc_any),
        .wdata       (wdata),
        .update_en   (do_mem),
        .update_slot (stepped),
        .phase       (cfg_phase),
        .pair        (cfg_pair),
        .arm         (arm),
        .cfg_rdata   (cfg_rdata)
    );

    pmac_slot_bank #(
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (acc_sel),
        .is_wr    (acc_wr),
        .load_en  (arm || do_mem),
        .load_val (do_mem ? stepped : cur),
        .cur      (stored)
    );

    // The arming access is served with the freshly programmed pair.
    assign cur = arm ? cfg_pair : stored;

    pmac_mode_dec u_dec (
        .mode      (cur.mode),
        .addr      (cur.addr),
        .is_wr     (acc_wr),
        .ok        (dec_ok),
        .tgt       (dec_tgt),
        .next_addr (dec_next),
        .byte_addr (dec_baddr)
    );

    // Stepped slot and memory request outputs.
    always_comb begin
        stepped   = '{addr: dec_next, mode: cur.mode};
        do_mem    = acc_any && routed && dec_ok;
        mem_req   = do_mem;
        mem_we    = do_mem && acc_wr;
        mem_tgt   = do_mem ? dec_tgt : TGT_DRAM;
        mem_addr  = do_mem ? dec_baddr : '0;
        mem_wdata = wdata;
        mode_err  = acc_any && routed && !dec_ok;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_plain
        logic [WORD_W-1:0] val_r;
        // Plain register write when the access is not routed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_r <= '0;
            else if (acc_wr && sel_ok && !routed && (acc_sel == SEL_W'(g)))
                val_r <= wdata;
        end
        assign plain_q[g] = val_r;
    end

    // Pick the plain register addressed by acc_sel.
    always_comb begin
        plain_sel = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (acc_sel == SEL_W'(i)) plain_sel = plain_q[i];
    end

    // Read data toward the core.
    always_comb begin
        rdata = '0;
        if (cfg_rd)
            rdata = cfg_rdata;
        else if (acc_rd && sel_ok) begin
            if (!routed)     rdata = plain_sel;
            else if (dec_ok) rdata = mem_rdata;
        end
    end
endmodule

// File: rtl/pmac_ctrl_chk.sv
// Checker for pmac_ctrl: port-level properties of requests, errors and
// the arming phase. Assumes at most one strobe per cycle.
module pmac_ctrl_chk
    import pmac_pkg::*;
#(
    parameter int NUM_REGS  = 5,
    parameter int ROUTE_REG = 4,
    parameter int SEL_W     = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SEL_W-1:0]   acc_sel,
    input logic               acc_rd,
    input logic               acc_wr,
    input logic               cfg_rd,
    input logic               cfg_wr,
    input logic [1:0]         gp_sel,
    input logic               mem_req,
    input logic               mem_we,
    input logic [1:0]         mem_tgt,
    input logic [BADDR_W-1:0] mem_addr,
    input logic               mode_err,
    input logic [1:0]         cfg_phase
);
    // R10: requests only for strobed, routed registers
    assert_req_routed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (acc_rd || acc_wr) &&
                    ((acc_sel == SEL_W'(ROUTE_REG)) || (gp_sel != 2'b00)));

    // R11: an error never comes with a request
    assert_err_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !mem_req);

    // R3: request direction follows the strobe
    assert_dir_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_we == acc_wr));

    // R8: instruction RAM requests are writes within its range
    assert_iram_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_tgt == 2'd2) |->
            (mem_we && ((mem_addr >> (IRAM_AW + 1)) == '0) && !mem_addr[0]));

    // R6: ROM requests are reads
    assert_rom_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_tgt == 2'd1) |-> !mem_we);

    // R2: an access while pending returns the sequencer to the address phase
    assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_rd || acc_wr) && (int'(acc_sel) < NUM_REGS) && !cfg_rd && !cfg_wr &&
         cfg_phase == 2'd2) |=> (cfg_phase == 2'd0));
endmodule

bind pmac_ctrl pmac_ctrl_chk #(
    .NUM_REGS  (NUM_REGS),
    .ROUTE_REG (ROUTE_REG),
    .SEL_W     (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_sel   (acc_sel),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .cfg_rd    (cfg_rd),
    .cfg_wr    (cfg_wr),
    .gp_sel    (gp_sel),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_tgt   (mem_tgt),
    .mem_addr  (mem_addr),
    .mode_err  (mode_err),
    .cfg_phase (cfg_phase)
);

// File: tb/tb_pmac_ctrl.sv
// Scoreboard bench: the driver pushes one expected item per strobe, the
// monitor pops it mid-cycle and compares every output.
module tb_pmac_ctrl;
    import pmac_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  acc_sel = '0;
    logic        acc_rd = 1'b0, acc_wr = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [1:0]  gp_sel = '0;
    logic [15:0] mem_rdata;
    logic        mem_req, mem_we, mode_err;
    logic [1:0]  mem_tgt;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        logic        req;
        logic        we;
        logic [1:0]  tgt;
        logic [23:0] ba;
        logic        err;
        logic [15:0] rd;
        logic [15:0] wd;
    } exp_t;

    exp_t q[$];
    exp_t e;

    pmac_ctrl dut (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_rd(acc_rd),
        .acc_wr(acc_wr), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .wdata(wdata),
        .gp_sel(gp_sel), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rdata(rdata), .mode_err(mode_err)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] mdl(input logic [1:0] t, input logic [23:0] ba);
        return ba[16:1] ^ {14'h0, t} ^ 16'h5A3C;
    endfunction

    // memory model answers reads in the request cycle
    assign mem_rdata = (mem_req && !mem_we) ? mdl(mem_tgt, mem_addr) : 16'h0;

    function automatic logic [23:0] dba(input logic [15:0] m, input logic [15:0] a);
        return {m[6:0], a, 1'b0};
    endfunction

    function automatic logic [23:0] iba(input logic [15:0] a);
        return {13'h0, a[9:0], 1'b0};
    endfunction

    function automatic exp_t mk(input string tag, input logic req, input logic we,
                                input logic [1:0] tgt, input logic [23:0] ba,
                                input logic err, input logic [15:0] rd,
                                input logic [15:0] wd);
        exp_t x;
        x.tag = tag; x.req = req; x.we = we; x.tgt = tgt; x.ba = ba;
        x.err = err; x.rd = rd; x.wd = wd;
        return x;
    endfunction

    task automatic chk(input string tag, input string fld,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    // monitor: compare outputs mid-cycle against the next expected item
    always @(negedge clk) begin
        #5;
        if (cfg_rd || cfg_wr || acc_rd || acc_wr) begin
            if (q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard underflow actual=strobe expected=none");
            end else begin
                e = q.pop_front();
                chk(e.tag, "mem_req", 32'(mem_req), 32'(e.req));
                chk(e.tag, "mode_err", 32'(mode_err), 32'(e.err));
                chk(e.tag, "rdata", 32'(rdata), 32'(e.rd));
                if (e.req) begin
                    chk(e.tag, "mem_we", 32'(mem_we), 32'(e.we));
                    chk(e.tag, "mem_tgt", 32'(mem_tgt), 32'(e.tgt));
                    chk(e.tag, "mem_addr", 32'(mem_addr), 32'(e.ba));
                    if (e.we) chk(e.tag, "mem_wdata", 32'(mem_wdata), 32'(e.wd));
                end
            end
        end
    end

    // driver: one strobe for one cycle, expected item pushed alongside
    task automatic go(input logic cw, input logic cr, input logic aw, input logic ar,
                      input logic [2:0] s, input logic [15:0] d, input exp_t x);
        @(negedge clk);
        cfg_wr = cw; cfg_rd = cr; acc_wr = aw; acc_rd = ar; acc_sel = s; wdata = d;
        q.push_back(x);
        @(posedge clk);
        #1;
        cfg_wr = 1'b0; cfg_rd = 1'b0; acc_wr = 1'b0; acc_rd = 1'b0;
    endtask

    task automatic prog(input logic [15:0] a, input logic [15:0] m);
        go(1, 0, 0, 0, 3'd0, a, mk("R2 cfg address", 0, 0, 0, 0, 0, 0, 0));
        go(1, 0, 0, 0, 3'd0, m, mk("R2 cfg mode", 0, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic cfg_rb(input logic [15:0] v, input string tag);
        go(0, 1, 0, 0, 3'd0, 16'h0, mk(tag, 0, 0, 0, 0, 0, v, 0));
    endtask

    task automatic rdm(input logic [2:0] s, input logic [1:0] t, input logic [23:0] ba,
                       input string tag);
        go(0, 0, 0, 1, s, 16'h0, mk(tag, 1, 0, t, ba, 0, mdl(t, ba), 0));
    endtask

    task automatic wrm(input logic [2:0] s, input logic [15:0] d, input logic [1:0] t,
                       input logic [23:0] ba, input string tag);
        go(0, 0, 1, 0, s, d, mk(tag, 1, 1, t, ba, 0, 0, d));
    endtask

    task automatic rdp(input logic [2:0] s, input logic [15:0] v, input string tag);
        go(0, 0, 0, 1, s, 16'h0, mk(tag, 0, 0, 0, 0, 0, v, 0));
    endtask

    task automatic wrp(input logic [2:0] s, input logic [15:0] d, input string tag);
        go(0, 0, 1, 0, s, d, mk(tag, 0, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic acc_err(input logic is_w, input logic [2:0] s, input string tag);
        go(0, 0, is_w, !is_w, s, 16'h0, mk(tag, 0, 0, 0, 0, 1, 0, 0));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #5;
        chk("R1 reset", "mem_req", 32'(mem_req), 0);
        chk("R1 reset", "mode_err", 32'(mode_err), 0);
        chk("R1 reset", "rdata", 32'(rdata), 0);
        cfg_rb(16'h0000, "R1 cfg address after reset");
        cfg_rb(16'h0000, "R1 cfg mode after reset");

        // R5 +1 stream, then R9 readback of stepped pair
        prog(16'h0100, 16'h0818);
        for (int i = 0; i < 3; i++)
            rdm(3'd4, 2'd0, dba(16'h0818, 16'h0100 + 16'(i)), "R5 R4 inc1");
        cfg_rb(16'h0103, "R9 stepped address");
        cfg_rb(16'h0818, "R9 mode word");

        prog(16'h0010, 16'h3018);
        rdm(3'd4, 2'd0, dba(16'h3018, 16'h0010), "R5 inc32");
        rdm(3'd4, 2'd0, dba(16'h3018, 16'h0030), "R5 inc32");
        rdm(3'd4, 2'd0, dba(16'h3018, 16'h0050), "R5 inc32");

        prog(16'h0005, 16'hA818);
        rdm(3'd4, 2'd0, dba(16'hA818, 16'h0005), "R5 dec16");
        rdm(3'd4, 2'd0, dba(16'hA818, 16'hFFF5), "R5 dec16 wrap");
        rdm(3'd4, 2'd0, dba(16'hA818, 16'hFFE5), "R5 dec16");

        prog(16'h1000, 16'hB818);
        rdm(3'd4, 2'd0, dba(16'hB818, 16'h1000), "R5 dec128");
        rdm(3'd4, 2'd0, dba(16'hB818, 16'h0F80), "R5 dec128");

        prog(16'h0200, 16'h0018);
        rdm(3'd4, 2'd0, dba(16'h0018, 16'h0200), "R5 hold");
        rdm(3'd4, 2'd0, dba(16'h0018, 16'h0200), "R5 hold");

        prog(16'hFFFF, 16'h0809);
        rdm(3'd4, 2'd1, dba(16'h0809, 16'hFFFF), "R6 R4 rom");
        rdm(3'd4, 2'd1, dba(16'h0809, 16'h0000), "R6 rom wrap");

        // R3: write slot armed separately, read slot keeps its stream
        prog(16'h0040, 16'h0818);
        wrm(3'd4, 16'h1111, 2'd0, dba(16'h0818, 16'h0040), "R3 R7 arm write");
        rdm(3'd4, 2'd1, dba(16'h0809, 16'h0001), "R3 read slot kept");
        wrm(3'd4, 16'h2222, 2'd0, dba(16'h0818, 16'h0041), "R3 R7 write inc1");
        cfg_rb(16'h0042, "R9 last accessed address");
        cfg_rb(16'h0818, "R9 last accessed mode");

        prog(16'h0002, 16'h4018);
        wrm(3'd4, 16'hA001, 2'd0, dba(16'h4018, 16'h0002), "R7 cell even");
        wrm(3'd4, 16'hA002, 2'd0, dba(16'h4018, 16'h0003), "R7 cell odd");
        wrm(3'd4, 16'hA003, 2'd0, dba(16'h4018, 16'h0022), "R7 cell");

        prog(16'h83FE, 16'h081C);
        wrm(3'd4, 16'hB001, 2'd2, iba(16'h83FE), "R8 iram inc1");
        wrm(3'd4, 16'hB002, 2'd2, iba(16'h83FF), "R8 iram inc1");
        wrm(3'd4, 16'hB003, 2'd2, iba(16'h8400), "R8 iram mask");
        prog(16'h0001, 16'h101C);
        wrm(3'd4, 16'hB004, 2'd2, iba(16'h0001), "R8 iram inc2");
        wrm(3'd4, 16'hB005, 2'd2, iba(16'h0003), "R8 iram inc2");

        // R10 / R12: plain registers and steering
        gp_sel = 2'b00;
        wrp(3'd1, 16'hBEEF, "R10 plain write");
        prog(16'h0300, 16'h0818);
        rdp(3'd1, 16'hBEEF, "R10 arming plain read");
        gp_sel = 2'b01;
        rdm(3'd1, 2'd0, dba(16'h0818, 16'h0300), "R10 steered read");
        acc_err(1'b0, 3'd2, "R12 R11 unarmed neighbour");
        gp_sel = 2'b10;
        rdm(3'd1, 2'd0, dba(16'h0818, 16'h0301), "R12 stream intact");
        gp_sel = 2'b00;
        rdp(3'd1, 16'hBEEF, "R10 plain kept");
        rdp(3'd0, 16'h0000, "R10 untouched plain");

        // R11 unknown mode
        prog(16'h0077, 16'h1234);
        acc_err(1'b0, 3'd4, "R11 unknown read mode");
        acc_err(1'b0, 3'd4, "R11 repeat");
        cfg_rb(16'h0077, "R11 address unchanged");
        cfg_rb(16'h1234, "R11 mode readback");
        acc_err(1'b1, 3'd4, "R11 unknown write mode");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
        end
        finish_run();
    end
endmodule